// File: doc/BRIEF.md
# Set-Associative TLB Command Unit

This block holds the main translation table of a memory management unit: 128 sets with a parameterized number of ways (2 or 4). Software controls it through four registers. The page descriptor register holds the virtual page number, flag bits, a present bit and an 8-bit ASID. The frame register holds the physical frame and permission bits. The third register is a slot index, and the fourth is a command register that starts an operation.

Four operations are available:
- **Probe:** searches every way of the addressed set for an entry that matches both the page and the ASID.
- **Get-index:** chooses a slot for a new entry.
- **Write:** stores both descriptor registers into the indexed slot.
- **Read:** loads both descriptor registers from the indexed slot.

Each command takes a fixed two cycles. While a command runs the unit shows busy and ignores every register write. Page-table walking and the small per-pipeline caches in front of this table belong elsewhere.

Top module: `tlb_cmd_unit`

## Requirements
- R1: After reset all four registers read zero, busy is low, and every slot is empty (present bit clear).
- R2: Slot numbering is linear: slot = set × WAYS + way, where set = page descriptor bits [19:13]. A software write to the index register keeps bit 31 and the low log2(128×WAYS) bits and clears every other bit.
- R3: On a probe with exactly one matching way, the index register receives that way's linear slot number with bit 31 clear. A way matches when its present bit (bit 8) is set and both its page number (bits [31:13]) and its ASID (bits [7:0]) equal those of the page descriptor register.
- R4: A probe with no matching way sets the index register to 0x80000000 (bit 31 is the lookup error flag).
- R5: A probe with more than one matching way sets the index register to 0x80000001 (error flag plus duplicate bit 0).
- R6: Get-index writes into the index register the slot of the lowest-numbered way in the page's set whose present bit is clear.
- R7: Each set has a victim pointer. When every way of a set is present, get-index returns the way named by that pointer. A write command to the way the pointer names advances the pointer by one, wrapping to way 0 after the last way. The pointer is zero after reset.
- R8: The write command stores both descriptor registers at the slot named by the low index bits. Writing zero to both registers erases the slot, so later probes no longer match it.
- R9: The read command copies the slot named by the low index bits into both descriptor registers.
- R10: The command register accepts codes 1 (probe), 2 (get-index), 3 (write) and 4 (read).
  - An accepted code raises busy for exactly two cycles, and the result appears as busy falls.
  - Any other code is ignored.
  - Register writes made while busy is high have no effect.
  - When the unit is idle and no register is written, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 page descriptor, 1 frame, 2 index, 3 command |
| reg_wdata | input | 32 | Register write data |
| pd0_q | output | 32 | Page descriptor register |
| pd1_q | output | 32 | Frame descriptor register |
| idx_q | output | 32 | Index register with error flags |
| busy | output | 1 | A command is in progress |

## Verification
A command in flight and a software register write can land in the same cycle. The bench provokes this by writing new data to the page descriptor register in the cycle right after a probe is issued. It then checks two things: the probe result still reflects the old descriptor, and the descriptor register still holds its earlier value after busy falls.

A second overlap is a write command that also moves a set's victim pointer. This is judged through the get-index results that follow, once a set is full and again after entries are erased. Every clock, a behavioural model in the bench is compared against all four outputs.

// File: rtl/tlb_cmd_unit.sv
module tlb_cmd_unit #(
  parameter int WAYS     = 4,
  parameter int SET_BITS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] pd0_q,
  output logic [31:0] pd1_q,
  output logic [31:0] idx_q,
  output logic        busy
);
  localparam int WB      = $clog2(WAYS);
  localparam int EB      = SET_BITS + WB;
  localparam int ENTRIES = WAYS << SET_BITS;
  localparam int SETS    = 1 << SET_BITS;
  localparam int PG      = 13;
  localparam int PRES    = 8;

  localparam logic [2:0] OP_PROBE = 3'd1;
  localparam logic [2:0] OP_GETIX = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_READ  = 3'd4;

  logic [31:0]   pd0_mem [ENTRIES];
  logic [31:0]   pd1_mem [ENTRIES];
  logic [WB-1:0] rr      [SETS];
  logic [1:0]    cnt;
  logic [2:0]    op;

  wire [SET_BITS-1:0] set_sel = pd0_q[PG +: SET_BITS];
  wire [EB-1:0]       widx    = idx_q[EB-1:0];
  wire [SET_BITS-1:0] wset    = widx[EB-1:WB];
  wire [WB-1:0]       wway    = widx[WB-1:0];
  wire                accept  = reg_we && !busy;
  wire                cmd_ok  = accept && reg_sel == 2'd3 &&
                                reg_wdata[2:0] >= OP_PROBE && reg_wdata[2:0] <= OP_READ;

  assign busy = cnt != 2'd0;

  logic [WB:0]   hits;
  logic [WB-1:0] hit_way;
  logic          free_found;
  logic [WB-1:0] free_way;
  logic [31:0]   ent;

  always_comb begin
    hits       = '0;
    hit_way    = '0;
    free_found = 1'b0;
    free_way   = '0;
    ent        = '0;
    for (int w = 0; w < WAYS; w++) begin
      ent = pd0_mem[{set_sel, WB'(w)}];
      if (ent[PRES] && ent[31:PG] == pd0_q[31:PG] && ent[7:0] == pd0_q[7:0]) begin
        if (hits == '0) hit_way = WB'(w);
        hits = hits + 1'b1;
      end
      if (!ent[PRES] && !free_found) begin
        free_found = 1'b1;
        free_way   = WB'(w);
      end
    end
  end

  wire [WB-1:0] victim = free_found ? free_way : rr[set_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pd0_q <= '0;
      pd1_q <= '0;
      idx_q <= '0;
      cnt   <= '0;
      op    <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        pd0_mem[i] <= '0;
        pd1_mem[i] <= '0;
      end
      for (int s = 0; s < SETS; s++) rr[s] <= '0;
    end else if (cmd_ok) begin
      cnt <= 2'd2;
      op  <= reg_wdata[2:0];
    end else if (busy) begin
      cnt <= cnt - 2'd1;
      if (cnt == 2'd1) begin
        case (op)
          OP_PROBE:
            if (hits == '0)     idx_q <= 32'h8000_0000;
            else if (hits > 1)  idx_q <= 32'h8000_0001;
            else                idx_q <= {1'b0, {(31-EB){1'b0}}, set_sel, hit_way};
          OP_GETIX: idx_q <= {1'b0, {(31-EB){1'b0}}, set_sel, victim};
          OP_WRITE: begin
            pd0_mem[widx] <= pd0_q;
            pd1_mem[widx] <= pd1_q;
            if (rr[wset] == wway) rr[wset] <= rr[wset] + 1'b1;
          end
          OP_READ: begin
            pd0_q <= pd0_mem[widx];
            pd1_q <= pd1_mem[widx];
          end
          default: ;
        endcase
      end
    end else if (accept) begin
      case (reg_sel)
        2'd0: pd0_q <= reg_wdata;
        2'd1: pd1_q <= reg_wdata;
        2'd2: idx_q <= {reg_wdata[31], {(31-EB){1'b0}}, reg_wdata[EB-1:0]};
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlb_cmd_unit_chk.sv
module tlb_cmd_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [31:0] pd0_q,
  input logic [31:0] pd1_q,
  input logic [31:0] idx_q,
  input logic        busy,
  input logic [2:0]  op
);
  AST_BUSY_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy); // R10
  AST_BUSY_TWO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |=> !busy); // R10
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !reg_we |=> $stable(pd0_q) && $stable(pd1_q) && $stable(idx_q)); // R10
  AST_BUSY_GUARDS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> $stable(pd0_q) && $stable(pd1_q)); // R10
  AST_MISS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && op == 3'd1 && idx_q[31] |-> idx_q[30:1] == 30'd0); // R4
  AST_PROBE_KEEPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && op == 3'd1 |-> $stable(pd0_q) && $stable(pd1_q)); // R3
endmodule

bind tlb_cmd_unit tlb_cmd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .pd0_q(pd0_q), .pd1_q(pd1_q),
  .idx_q(idx_q), .busy(busy), .op(op)
);

// File: tb/sim_tlb_cmd_unit.sv
module sim_tlb_cmd_unit;
  localparam int W = 4;
  localparam int NENT = 128 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] pd0_q, pd1_q, idx_q;
  logic busy;

  tlb_cmd_unit #(.WAYS(W), .SET_BITS(7)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .pd0_q(pd0_q), .pd1_q(pd1_q), .idx_q(idx_q), .busy(busy)
  );

  always #2.5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference model
  logic [31:0] m_pd0, m_pd1, m_idx;
  logic [31:0] m_t0 [NENT];
  logic [31:0] m_t1 [NENT];
  int m_ptr [128];
  int m_cnt, m_op;

  function automatic bool_match(logic [31:0] e, logic [31:0] key);
    return e[8] && e[31:13] == key[31:13] && e[7:0] == key[7:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pd0 = 0; m_pd1 = 0; m_idx = 0; m_cnt = 0; m_op = 0;
      for (int i = 0; i < NENT; i++) begin m_t0[i] = 0; m_t1[i] = 0; end
      for (int s = 0; s < 128; s++) m_ptr[s] = 0;
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin
        int s, n, first, slot;
        s = int'(m_pd0[19:13]);
        slot = int'(m_idx[8:0]);
        if (m_op == 1) begin
          n = 0; first = 0;
          for (int w = 0; w < W; w++)
            if (bool_match(m_t0[s*W+w], m_pd0)) begin
              if (n == 0) first = w;
              n++;
            end
          if (n == 0) m_idx = 32'h8000_0000;
          else if (n > 1) m_idx = 32'h8000_0001;
          else m_idx = s*W + first;
        end else if (m_op == 2) begin
          first = -1;
          for (int w = W-1; w >= 0; w--) if (!m_t0[s*W+w][8]) first = w;
          if (first < 0) first = m_ptr[s];
          m_idx = s*W + first;
        end else if (m_op == 3) begin
          m_t0[slot] = m_pd0; m_t1[slot] = m_pd1;
          if (m_ptr[slot / W] == slot % W) m_ptr[slot / W] = (m_ptr[slot / W] + 1) % W;
        end else if (m_op == 4) begin
          m_pd0 = m_t0[slot]; m_pd1 = m_t1[slot];
        end
      end
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: m_pd0 = reg_wdata;
        2'd1: m_pd1 = reg_wdata;
        2'd2: m_idx = (reg_wdata & 32'h8000_0000) | (reg_wdata & (NENT - 1));
        default: if (reg_wdata[2:0] >= 1 && reg_wdata[2:0] <= 4) begin
          m_cnt = 2; m_op = int'(reg_wdata[2:0]);
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      compared++;
      if (pd0_q !== m_pd0 || pd1_q !== m_pd1 || idx_q !== m_idx || busy !== (m_cnt != 0)) begin
        mismatched++;
        $display("FAIL %s cycle: pd0 %h/%h pd1 %h/%h idx %h/%h busy %b/%b (actual/expected)",
                 cur_req, pd0_q, m_pd0, pd1_q, m_pd1, idx_q, m_idx, busy, m_cnt != 0);
      end
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(int sel, logic [31:0] d);
    reg_we = 1'b1; reg_sel = sel[1:0]; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic cmd(int code);
    wr(3, code);
    repeat (2) begin @(posedge clk); #1; end
  endtask

  function automatic logic [31:0] mk(int k, int asid, bit p);
    return ((32'(5 + 128*k)) << 13) | (32'(p) << 8) | 32'(asid & 8'hff);
  endfunction

  task automatic install(int k, logic [31:0] frame, int exp_slot, string r);
    wr(0, mk(k, 3, 1));
    cmd(2);
    chk(r, idx_q, exp_slot);
    wr(1, frame);
    cmd(3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    cur_req = "R1";
    chk("R1 pd0", pd0_q, 0); chk("R1 pd1", pd1_q, 0);
    chk("R1 idx", idx_q, 0); chk("R1 busy", 32'(busy), 0);

    cur_req = "R6";
    install(1, 32'hCAFE_0001, 20, "R6 empty set way0");
    cur_req = "R3";
    wr(0, mk(1, 3, 1)); cmd(1);
    chk("R3 probe hit", idx_q, 20);

    cur_req = "R9";
    wr(0, 0); wr(1, 0); wr(2, 20); cmd(4);
    chk("R9 read pd0", pd0_q, mk(1, 3, 1));
    chk("R9 read pd1", pd1_q, 32'hCAFE_0001);

    cur_req = "R4";
    wr(0, mk(2, 3, 1)); cmd(1);
    chk("R4 vpn miss", idx_q, 32'h8000_0000);
    wr(0, mk(1, 4, 1)); cmd(1);
    chk("R4 asid miss", idx_q, 32'h8000_0000);

    cur_req = "R6";
    install(2, 32'h1111_0002, 21, "R6 way1");
    install(3, 32'h1111_0003, 22, "R6 way2");
    install(4, 32'h1111_0004, 23, "R6 way3");

    cur_req = "R7";
    install(5, 32'h2222_0005, 20, "R7 full set ptr way0");
    install(6, 32'h2222_0006, 21, "R7 ptr advanced way1");

    cur_req = "R5";
    wr(0, mk(7, 3, 1)); wr(1, 32'h3333_0007);
    wr(2, 22); cmd(3);
    wr(2, 23); cmd(3);
    cmd(1);
    chk("R5 duplicate", idx_q, 32'h8000_0001);

    cur_req = "R8";
    wr(0, 0); wr(1, 0); wr(2, 22); cmd(3);
    wr(0, mk(7, 3, 1)); cmd(1);
    chk("R8 erase one copy", idx_q, 23);
    wr(0, 0); wr(2, 23); cmd(3);
    wr(0, mk(7, 3, 1)); cmd(1);
    chk("R8 erase both", idx_q, 32'h8000_0000);
    cur_req = "R6";
    cmd(2);
    chk("R6 first free after erase", idx_q, 22);

    cur_req = "R2";
    wr(2, 32'h7FFF_FFFF);
    chk("R2 index mask", idx_q, 32'h0000_01FF);
    wr(2, 32'hFFFF_FE15);
    chk("R2 index mask err", idx_q, 32'h8000_0015);
    wr(0, 32'h0000_2000 * 9); wr(1, 32'hABCD_0009); wr(2, 9*W + 2); cmd(3);
    wr(0, 0); wr(1, 0); cmd(4);
    chk("R2 slot set9 way2", pd1_q, 32'hABCD_0009);

    cur_req = "R10";
    wr(0, mk(6, 3, 1));
    wr(3, 1);
    chk("R10 busy after issue", 32'(busy), 1);
    wr(0, 32'hDEAD_BEEF);
    chk("R10 busy second cycle", 32'(busy), 1);
    @(posedge clk); #1;
    chk("R10 busy done", 32'(busy), 0);
    chk("R10 pd0 write ignored", pd0_q, mk(6, 3, 1));
    chk("R10 probe result", idx_q, 21);
    wr(3, 7);
    chk("R10 bad code no busy", 32'(busy), 0);
    chk("R10 bad code idx kept", idx_q, 21);

    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule